// File: doc/BRIEF.md
# System Clock Ratio Detector

This block works out how many system-clock cycles make up one period of the left/right word clock, and maps that count to one of six supported oversampling ratios: 128, 192, 256, 384, 512 or 768. The word clock is synchronous to the system clock. It is brought into the system-clock domain through a two-flop synchroniser, and the number of cycles between successive rising edges is counted. A ratio is reported only when two back-to-back periods land in the same ratio class. The block reports lock once the class has held for several more periods. An unsupported period length clears the result and keeps downstream audio muted.

The same block produces the internal reset. Two sources assert it at once: the active-low external reset and a low power-good input. The release of these sources passes through an asynchronous-assert, synchronous-deassert synchroniser. The internal reset then stays active for a fixed initialisation sequence of 1024 system clocks. All measurement state is held cleared while the internal reset is active.

Top module: `sysclk_ratio_detector`

## Requirements
- R1: While extRstN is low or powerGood is low, intRst is 1. Within two system clocks the outputs are also cleared: ratioValid=0, locked=0, ratioOneHot=0, ratioCode=0 and muteHold=1.
- R2: After both reset sources are inactive, intRst stays 1 for INIT_CYCLES (1024) system clocks plus a synchroniser delay of at most 3 clocks. It is therefore still 1 1000 clocks after release and is 0 by 1040 clocks after release.
- R3: The period is the count of system clocks between rising edges of the synchronised word clock. The ratio code is 0=128, 1=192, 2=256, 3=384, 4=512 and 5=768. Bit k of ratioOneHot is set for code k while ratioValid is 1.
- R4: A period matches a ratio when it lies within plus or minus TOL (2) cycles of that ratio. For example, 126 and 386 are accepted, and 387 is rejected.
- R5: ratioValid rises only after two consecutive measured periods fall in the same ratio class. With one such period, or with two periods in different classes, it stays 0.
- R6: A measured period that matches no ratio clears ratioValid and locked, and drives ratioOneHot and ratioCode to 0.
- R7: locked becomes 1 after LOCK_PERIODS (4) consecutive periods in the same class. locked is 1 only while ratioValid is 1.
- R8: muteHold is 1 whenever intRst is 1 or ratioValid is 0, and 0 otherwise.
- R9: When the period changes to a different supported ratio, the new code is reported after two periods of the new length, and locked restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| extRstN | input | 1 | External reset, active low |
| powerGood | input | 1 | Supply-good indication, low forces reset |
| wordClk | input | 1 | Left/right word clock, synchronous to clk |
| ratioOneHot | output | 6 | One-hot ratio, bit k for code k |
| ratioCode | output | 3 | Encoded ratio (0..5) |
| ratioValid | output | 1 | Two consecutive periods agree on a ratio |
| locked | output | 1 | Ratio has held for LOCK_PERIODS periods |
| muteHold | output | 1 | Request to keep the audio datapath muted |
| intRst | output | 1 | Internal reset, active high |

## Verification
The assertions check several rules on every cycle:
- the one-hot output has exactly one bit set while a ratio is valid;
- lock never appears without validity;
- validity rises only right after a matching measurement;
- a rejected measurement always clears validity;
- the internal reset releases only after the synchroniser has released.

Other behaviour can be shown only by the bench's scenarios. These are the exact initialisation length, the ratio chosen for each of the six period lengths, the tolerance edges at plus or minus 2 and 3 cycles, the two-period confirmation, and re-acquisition after a ratio change or a power-good drop.

// File: rtl/srd_pkg.sv
package srd_pkg;
  localparam int NUM_RATIOS = 6;
  localparam int IDX_W = 3;

  // 128,192,256,384,512,768 indexed 0..5
  function automatic int ratioVal(input int i);
    return ((i % 2) == 0) ? (128 << (i / 2)) : (192 << (i / 2));
  endfunction

  typedef struct packed {
    logic             measDone;
    logic             hit;
    logic [IDX_W-1:0] idx;
  } measStrb_t;
endpackage

// File: rtl/srd_reset_seq.sv
module srd_reset_seq #(
  parameter int INIT_CYCLES = 1024
) (
  input  logic clk,
  input  logic extRstN,
  input  logic powerGood,
  output logic intRst
);
  localparam int CW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;

  logic          rawRstN;
  logic [1:0]    relSync;
  logic          syncN;
  logic [CW-1:0] initCnt;

  assign rawRstN = extRstN & powerGood;
  assign syncN   = relSync[1];

  always_ff @(posedge clk or negedge rawRstN) begin
    if (!rawRstN) relSync <= 2'b00;
    else          relSync <= {relSync[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rawRstN) begin
    if (!rawRstN) begin
      initCnt <= '0;
      intRst  <= 1'b1;
    end else if (syncN && intRst) begin
      if (initCnt == CW'(INIT_CYCLES - 1)) intRst <= 1'b0;
      else                                 initCnt <= initCnt + 1'b1;
    end
  end

  // R2: release only once the synchronised release is seen
  p_release_after_sync_r2: assert property (@(posedge clk) disable iff (!rawRstN)
    $fell(intRst) |-> $past(syncN));
endmodule

// File: rtl/srd_meas_dp.sv
module srd_meas_dp
  import srd_pkg::*;
#(
  parameter int TOL   = 2,
  parameter int CNT_W = 11
) (
  input  logic      clk,
  input  logic      intRst,
  input  logic      wordClk,
  output measStrb_t strb
);
  logic [2:0]            wcSync;
  logic                  wcRise;
  logic [CNT_W-1:0]      periodCnt;
  logic                  firstSeen;
  logic [NUM_RATIOS-1:0] hitVec;
  logic [IDX_W-1:0]      hitIdx;

  assign wcRise = wcSync[1] & ~wcSync[2];

  for (genvar gi = 0; gi < NUM_RATIOS; gi++) begin : g_cls
    localparam int LO = ratioVal(gi) - TOL;
    localparam int HI = ratioVal(gi) + TOL;
    assign hitVec[gi] = (int'(periodCnt) >= LO) && (int'(periodCnt) <= HI);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < NUM_RATIOS; i++)
      if (hitVec[i]) hitIdx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (intRst) begin
      wcSync    <= '0;
      periodCnt <= '0;
      firstSeen <= 1'b0;
      strb      <= '0;
    end else begin
      wcSync        <= {wcSync[1:0], wordClk};
      strb.measDone <= 1'b0;
      if (wcRise) begin
        periodCnt     <= CNT_W'(1);
        firstSeen     <= 1'b1;
        strb.measDone <= firstSeen;
        strb.hit      <= |hitVec;
        strb.idx      <= hitIdx;
      end else if (periodCnt != '1) begin
        periodCnt <= periodCnt + 1'b1;
      end
    end
  end

  // R3: a measurement is issued only right after a word-clock edge
  p_meas_after_edge_r3: assert property (@(posedge clk) disable iff (intRst)
    strb.measDone |-> $past(wcRise));
endmodule

// File: rtl/srd_lock_ctrl.sv
module srd_lock_ctrl
  import srd_pkg::*;
#(
  parameter int LOCK_PERIODS = 4
) (
  input  logic                  clk,
  input  logic                  intRst,
  input  measStrb_t             strb,
  output logic [IDX_W-1:0]      ratioCode,
  output logic [NUM_RATIOS-1:0] ratioOneHot,
  output logic                  ratioValid,
  output logic                  locked,
  output logic                  muteHold
);
  localparam int MW = $clog2(LOCK_PERIODS + 1);

  logic [MW-1:0]    matchCnt;
  logic [MW-1:0]    nextMatch;
  logic [IDX_W-1:0] lastIdx;
  logic             lastHit;
  logic [IDX_W-1:0] codeR;
  logic             sameClass;

  assign sameClass = lastHit && (strb.idx == lastIdx);
  assign nextMatch = (matchCnt == MW'(LOCK_PERIODS)) ? matchCnt : matchCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (intRst) begin
      matchCnt   <= '0;
      lastIdx    <= '0;
      lastHit    <= 1'b0;
      codeR      <= '0;
      ratioValid <= 1'b0;
      locked     <= 1'b0;
    end else if (strb.measDone) begin
      lastHit <= strb.hit;
      lastIdx <= strb.idx;
      if (!strb.hit) begin
        matchCnt   <= '0;
        ratioValid <= 1'b0;
        locked     <= 1'b0;
      end else if (sameClass) begin
        matchCnt   <= nextMatch;
        codeR      <= strb.idx;
        ratioValid <= nextMatch >= MW'(2);
        locked     <= nextMatch >= MW'(LOCK_PERIODS);
      end else begin
        matchCnt   <= MW'(1);
        codeR      <= strb.idx;
        ratioValid <= 1'b0;
        locked     <= 1'b0;
      end
    end
  end

  assign ratioCode = ratioValid ? codeR : '0;
  assign muteHold  = intRst | ~ratioValid;

  always_comb begin
    ratioOneHot = '0;
    for (int i = 0; i < NUM_RATIOS; i++)
      if (ratioValid && codeR == IDX_W'(i)) ratioOneHot[i] = 1'b1;
  end

  p_onehot_valid_r3: assert property (@(posedge clk) disable iff (intRst)
    ratioValid |-> ($countones(ratioOneHot) == 1));
  p_lock_needs_valid_r7: assert property (@(posedge clk) disable iff (intRst)
    locked |-> ratioValid);
  p_valid_after_hit_r5: assert property (@(posedge clk) disable iff (intRst)
    $rose(ratioValid) |-> $past(strb.measDone && strb.hit));
  p_miss_clears_r6: assert property (@(posedge clk) disable iff (intRst)
    (strb.measDone && !strb.hit) |=> !ratioValid);
endmodule

// File: rtl/sysclk_ratio_detector.sv
module sysclk_ratio_detector
  import srd_pkg::*;
#(
  parameter int INIT_CYCLES  = 1024,
  parameter int TOL          = 2,
  parameter int LOCK_PERIODS = 4
) (
  input  logic                  clk,
  input  logic                  extRstN,
  input  logic                  powerGood,
  input  logic                  wordClk,
  output logic [NUM_RATIOS-1:0] ratioOneHot,
  output logic [IDX_W-1:0]      ratioCode,
  output logic                  ratioValid,
  output logic                  locked,
  output logic                  muteHold,
  output logic                  intRst
);
  localparam int CNT_W = $clog2(ratioVal(NUM_RATIOS - 1) + TOL + 2) + 1;

  measStrb_t strb;

  srd_reset_seq #(.INIT_CYCLES(INIT_CYCLES)) u_rst (
    .clk(clk), .extRstN(extRstN), .powerGood(powerGood), .intRst(intRst)
  );

  srd_meas_dp #(.TOL(TOL), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .intRst(intRst), .wordClk(wordClk), .strb(strb)
  );

  srd_lock_ctrl #(.LOCK_PERIODS(LOCK_PERIODS)) u_ctrl (
    .clk(clk), .intRst(intRst), .strb(strb), .ratioCode(ratioCode),
    .ratioOneHot(ratioOneHot), .ratioValid(ratioValid), .locked(locked),
    .muteHold(muteHold)
  );
endmodule

// File: tb/sysclk_ratio_detector_tb.sv
module sysclk_ratio_detector_tb;
  logic       clk = 1'b0;
  logic       extRstN;
  logic       powerGood;
  logic       wordClk;
  logic [5:0] ratioOneHot;
  logic [2:0] ratioCode;
  logic       ratioValid, locked, muteHold, intRst;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  sysclk_ratio_detector u_dut (
    .clk(clk), .extRstN(extRstN), .powerGood(powerGood), .wordClk(wordClk),
    .ratioOneHot(ratioOneHot), .ratioCode(ratioCode), .ratioValid(ratioValid),
    .locked(locked), .muteHold(muteHold), .intRst(intRst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic period(input int len);
    wordClk = 1'b1;
    repeat (len / 2) @(negedge clk);
    wordClk = 1'b0;
    repeat (len - len / 2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1 intRst", int'(intRst), 1);
    chk("R1 valid", int'(ratioValid), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 onehot", int'(ratioOneHot), 0);
    chk("R1 code", int'(ratioCode), 0);
    chk("R8 mute in reset", int'(muteHold), 1);
  endtask

  task automatic t_init();
    extRstN = 1'b1;
    repeat (1000) @(negedge clk);
    chk("R2 still held", int'(intRst), 1);
    repeat (40) @(negedge clk);
    chk("R2 released", int'(intRst), 0);
  endtask

  // Switch to a supported period length and step through the acquisition.
  task automatic t_ratio(input int len, input int code, input string req);
    period(len); period(len);
    chk({req, " R5 one period not valid"}, int'(ratioValid), 0);
    period(len);
    chk({req, " R5 valid after two"}, int'(ratioValid), 1);
    chk({req, " R9 code"}, int'(ratioCode), code);
    chk({req, " R7 not yet locked"}, int'(locked), 0);
    period(len); period(len);
    chk({req, " R7 locked"}, int'(locked), 1);
    chk({req, " R3 onehot"}, int'(ratioOneHot), 1 << code);
    chk({req, " R8 mute off"}, int'(muteHold), 0);
  endtask

  task automatic t_reject(input int len, input string req);
    period(len); period(len); period(len);
    chk({req, " R6 valid"}, int'(ratioValid), 0);
    chk({req, " R6 locked"}, int'(locked), 0);
    chk({req, " R6 onehot"}, int'(ratioOneHot), 0);
    chk({req, " R6 code"}, int'(ratioCode), 0);
    chk({req, " R8 mute"}, int'(muteHold), 1);
  endtask

  task automatic t_power_drop();
    powerGood = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 power drop intRst", int'(intRst), 1);
    chk("R1 power drop valid", int'(ratioValid), 0);
    chk("R1 power drop mute", int'(muteHold), 1);
    powerGood = 1'b1;
    repeat (1040) @(negedge clk);
    chk("R2 released after power", int'(intRst), 0);
    period(384); period(384); period(384);
    chk("R3 reacquire valid", int'(ratioValid), 1);
    chk("R3 reacquire code", int'(ratioCode), 3);
  endtask

  initial begin
    extRstN = 1'b0;
    powerGood = 1'b1;
    wordClk = 1'b0;
    t_reset();
    t_init();
    t_ratio(128, 0, "R3 128");
    t_ratio(192, 1, "R3 192");
    t_ratio(256, 2, "R3 256");
    t_ratio(384, 3, "R3 384");
    t_ratio(512, 4, "R3 512");
    t_ratio(768, 5, "R3 768");
    t_ratio(386, 3, "R4 +2");
    t_ratio(126, 0, "R4 -2");
    t_reject(387, "R4 +3");
    t_reject(300, "R6 300");
    t_ratio(256, 2, "R9 to 256");
    t_ratio(512, 4, "R9 to 512");
    t_power_drop();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule